// File: doc/BRIEF.md
# Byte-Serial Burst Bus Target

This block is a target on a shared bus that moves one byte per clock. A master first presents a single-cycle address phase. In that cycle it drives a 32-bit address, a two-bit size code that selects 1, 2, 4 or 8 bytes, and one read strobe and one write strobe. The target latches these values on that edge. From the next cycle it runs a data phase, one byte beat after another, against a 256-byte register file inside the block. That register file is addressed by the low eight address bits.

The master paces the data phase with a burst flag that it holds high on every beat except the final one. The target paces it with a wait output. Before each beat the target stalls for a fixed number of cycles, from 0 to 3, taken from a configuration input in the address phase. A beat completes at the rising edge where wait is low. If the master's burst flag disagrees with the beat count, the target pulses an error flag and drops back to idle.

Top module: `byte_bus_target`

## Requirements
- R1: While reset (active high, synchronous) is applied, and in the first cycle after it, `busy_o`, `wait_o`, `proto_err_o` are 0 and `rdata_o` is 8'h00.
- R2: A transfer starts only from idle, and only when exactly one of `rd_i` and `wr_i` is 1 at a rising edge. If both are 0 or both are 1, the edge is a no-operation: `busy_o` stays 0 and no data phase follows.
- R3: Size code 2'b00, 2'b01, 2'b10 and 2'b11 gives 1, 2, 4 and 8 beats. `busy_o` is 1 from the cycle after the address phase through the cycle of the final beat, and is 0 in the cycle after that beat completes.
- R4: Before every beat, `wait_o` is 1 for exactly N cycles and then 0 for the completing cycle. N is the value of `wait_cfg_i` sampled in the address phase. Later changes of `wait_cfg_i` do not alter N within the transfer.
- R5: Beat k of a transfer uses memory location (addr_i[7:0] + k) mod 256, so a burst wraps from 8'hFF to 8'h00.
- R6: On a read transfer, `rdata_o` holds the addressed byte in the cycle in which `wait_o` is 0. In every other cycle it is 8'h00.
- R7: On a write transfer, the byte on `wdata_i` is stored at the completing edge of a beat when `rw_i` is 1. A beat completed with `rw_i` at 0 leaves the location unchanged.
- R8: A beat completed with `bip_i` at 0 before the last beat, or with `bip_i` at 1 on the last beat, still moves its byte. It then raises `proto_err_o` for exactly one cycle, in the cycle after that edge, and the target is idle in that same cycle.
- R9: Address, size and strobe inputs are ignored while a transfer is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | 32 | Address, valid in the address phase |
| size_i | input | 2 | Size code, valid in the address phase |
| rd_i | input | 1 | Read strobe of the address phase |
| wr_i | input | 1 | Write strobe of the address phase |
| wait_cfg_i | input | 2 | Stall cycles to insert before each beat |
| bip_i | input | 1 | Burst flag: 1 on every beat but the last |
| rw_i | input | 1 | Beat direction from master, 1 = write data present |
| wdata_i | input | 8 | Write byte from master |
| wait_o | output | 1 | Target stall, beat completes when 0 |
| rdata_o | output | 8 | Read byte to master |
| busy_o | output | 1 | Data phase in progress |
| proto_err_o | output | 1 | One-cycle pulse on a burst flag mismatch |

## Verification
All results follow from the address-phase edge by counting. `busy_o` rises in the very next cycle. Beat k completes (k+1)(N+1) cycles after the address phase. The error pulse and the return to idle appear in the cycle after the offending beat. The bench drives inputs on falling edges and reads outputs at the next falling edge. While `wait_o` is 1 it counts stall cycles, which it then compares with N. It samples read data only in the cycle where `wait_o` is 0. Each beat's result is therefore checked in the one cycle where the requirements place it, and never at a clock edge.

// File: rtl/bbt_pkg.sv
package bbt_pkg;

    localparam int BEAT_W = 3;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DATA = 1'b1
    } bbt_state_e;

    function automatic logic [BEAT_W-1:0] last_beat_of(input logic [1:0] code);
        return BEAT_W'((4'd1 << code) - 4'd1);
    endfunction

endpackage

// File: rtl/bbt_mem.sv
module bbt_mem #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we_i) begin
            cells_q[addr_i] <= wdata_i;
        end
    end

    assign rdata_o = cells_q[addr_i];

endmodule

// File: rtl/bbt_pacer.sv
module bbt_pacer #(
    parameter int WW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic          reload_i,
    input  logic [WW-1:0] cfg_i,
    output logic          stall_o
);
    typedef struct packed {
        logic [WW-1:0] n;
        logic [WW-1:0] cnt;
    } pacer_s;

    pacer_s pc_d, pc_q;

    always_comb begin
        pc_d = pc_q;
        if (start_i) begin
            pc_d.n   = cfg_i;
            pc_d.cnt = cfg_i;
        end else if (reload_i) begin
            pc_d.cnt = pc_q.n;
        end else if (pc_q.cnt != '0) begin
            pc_d.cnt = pc_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_d;
        end
    end

    assign stall_o = (pc_q.cnt != '0);

endmodule

// File: rtl/bbt_beat_ctrl.sv
module bbt_beat_ctrl
    import bbt_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr_i,
    input  logic [1:0]    size_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic          bip_i,
    input  logic          rw_i,
    input  logic          stall_i,
    output logic          start_o,
    output logic          reload_o,
    output logic          busy_o,
    output logic          rd_beat_o,
    output logic          we_o,
    output logic [AW-1:0] mem_addr_o,
    output logic          err_o
);
    typedef struct packed {
        bbt_state_e        state;
        logic [AW-1:0]     base;
        logic [BEAT_W-1:0] beat;
        logic [BEAT_W-1:0] last;
        logic              is_rd;
        logic              err;
    } ctrl_s;

    ctrl_s ct_d, ct_q;
    logic  done, at_last, bad_flag, start;

    always_comb begin
        ct_d     = ct_q;
        ct_d.err = 1'b0;
        reload_o = 1'b0;
        start    = (ct_q.state == ST_IDLE) && (rd_i ^ wr_i);
        done     = (ct_q.state == ST_DATA) && !stall_i;
        at_last  = (ct_q.beat == ct_q.last);
        bad_flag = done && (bip_i == at_last);
        if (start) begin
            ct_d.state = ST_DATA;
            ct_d.base  = addr_i;
            ct_d.beat  = '0;
            ct_d.last  = last_beat_of(size_i);
            ct_d.is_rd = rd_i;
        end else if (done) begin
            if (bad_flag) begin
                ct_d.err   = 1'b1;
                ct_d.state = ST_IDLE;
            end else if (at_last) begin
                ct_d.state = ST_IDLE;
            end else begin
                ct_d.beat = ct_q.beat + 1'b1;
                reload_o  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ct_q <= '0;
        end else begin
            ct_q <= ct_d;
        end
    end

    assign start_o    = start;
    assign busy_o     = (ct_q.state == ST_DATA);
    assign rd_beat_o  = done && ct_q.is_rd;
    assign we_o       = done && !ct_q.is_rd && rw_i;
    assign mem_addr_o = ct_q.base + AW'(ct_q.beat);
    assign err_o      = ct_q.err;

endmodule

// File: rtl/byte_bus_target.sv
module byte_bus_target #(
    parameter int ADDR_W = 32,
    parameter int MEM_AW = 8,
    parameter int DATA_W = 8,
    parameter int WAIT_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [WAIT_W-1:0] wait_cfg_i,
    input  logic              bip_i,
    input  logic              rw_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              wait_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              busy_o,
    output logic              proto_err_o
);
    logic              start, reload, stall, busy, rd_beat, we;
    logic [MEM_AW-1:0] mem_addr;
    logic [DATA_W-1:0] mem_rdata;

    bbt_beat_ctrl #(.AW(MEM_AW)) i_ctrl (
        .clk        (clk),
        .rst        (rst),
        .addr_i     (addr_i[MEM_AW-1:0]),
        .size_i     (size_i),
        .rd_i       (rd_i),
        .wr_i       (wr_i),
        .bip_i      (bip_i),
        .rw_i       (rw_i),
        .stall_i    (stall),
        .start_o    (start),
        .reload_o   (reload),
        .busy_o     (busy),
        .rd_beat_o  (rd_beat),
        .we_o       (we),
        .mem_addr_o (mem_addr),
        .err_o      (proto_err_o)
    );

    bbt_pacer #(.WW(WAIT_W)) i_pacer (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start),
        .reload_i (reload),
        .cfg_i    (wait_cfg_i),
        .stall_o  (stall)
    );

    bbt_mem #(.AW(MEM_AW), .DW(DATA_W)) i_mem (
        .clk     (clk),
        .we_i    (we),
        .addr_i  (mem_addr),
        .wdata_i (wdata_i),
        .rdata_o (mem_rdata)
    );

    assign busy_o  = busy;
    assign wait_o  = busy && stall;
    assign rdata_o = rd_beat ? mem_rdata : '0;

endmodule

// File: rtl/bbt_checker.sv
module bbt_checker #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rd_i,
    input logic              wr_i,
    input logic              wait_o,
    input logic [DATA_W-1:0] rdata_o,
    input logic              busy_o,
    input logic              proto_err_o
);
    logic past_rst;

    always_ff @(posedge clk) begin
        past_rst <= rst;
        if (past_rst) begin
            a_r1_reset_quiet: assert (!busy_o && !wait_o && !proto_err_o && rdata_o == '0);
        end
    end

    a_r2_nop_stays_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (rd_i == wr_i)) |=> !busy_o);

    a_r3_start_goes_busy: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && (rd_i ^ wr_i)) |=> busy_o);

    a_r4_wait_only_busy: assert property (@(posedge clk) disable iff (rst)
        wait_o |-> busy_o);

    a_r4_stall_keeps_busy: assert property (@(posedge clk) disable iff (rst)
        (busy_o && wait_o) |=> busy_o);

    a_r6_rdata_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy_o || wait_o) |-> (rdata_o == '0));

    a_r8_err_idle: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |-> !busy_o);

    a_r8_err_single: assert property (@(posedge clk) disable iff (rst)
        proto_err_o |=> !proto_err_o);

endmodule

bind byte_bus_target bbt_checker #(.DATA_W(DATA_W)) i_bbt_checker (
    .clk         (clk),
    .rst         (rst),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .wait_o      (wait_o),
    .rdata_o     (rdata_o),
    .busy_o      (busy_o),
    .proto_err_o (proto_err_o)
);

// File: tb/test_byte_bus_target.sv
`timescale 1ns/1ps
module test_byte_bus_target;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] addr_i = '0;
    logic [1:0]  size_i = '0;
    logic        rd_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [1:0]  wait_cfg_i = '0;
    logic        bip_i = 1'b0;
    logic        rw_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic        wait_o;
    logic [7:0]  rdata_o;
    logic        busy_o;
    logic        proto_err_o;

    int n_chk = 0;
    int n_fail = 0;
    logic [7:0] model [256];

    always #4 clk = ~clk;

    byte_bus_target i_byte_bus_target (
        .clk(clk), .rst(rst), .addr_i(addr_i), .size_i(size_i),
        .rd_i(rd_i), .wr_i(wr_i), .wait_cfg_i(wait_cfg_i), .bip_i(bip_i),
        .rw_i(rw_i), .wdata_i(wdata_i), .wait_o(wait_o), .rdata_o(rdata_o),
        .busy_o(busy_o), .proto_err_o(proto_err_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int beats_of(input logic [1:0] code);
        return 1 << code;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic scramble_addr_inputs();
        addr_i     = $urandom;
        size_i     = 2'($urandom);
        rd_i       = 1'($urandom);
        wr_i       = 1'($urandom);
        wait_cfg_i = 2'($urandom);
    endtask

    // mode: 0 clean, 1 burst flag drops early at beat ebeat, 2 flag stays high on last beat
    task automatic xfer(input logic [31:0] a, input logic [1:0] sz, input bit is_rd,
                        input logic [1:0] wn, input int mode, input int ebeat, input int skip_rw);
        int n;
        int stop;
        int cnt;
        int idx;
        n    = beats_of(sz);
        stop = (mode == 1) ? ebeat : n - 1;
        addr_i = a; size_i = sz; rd_i = is_rd; wr_i = !is_rd; wait_cfg_i = wn;
        step();
        check(busy_o == 1'b1, "R3", "busy after address phase", busy_o, 1);
        for (int k = 0; k <= stop; k++) begin
            scramble_addr_inputs(); // R9: ignored during the data phase
            if (mode == 1 && k == stop)      bip_i = 1'b0;
            else if (mode == 2 && k == n-1)  bip_i = 1'b1;
            else                             bip_i = (k != n - 1);
            rw_i    = !is_rd && (k != skip_rw);
            wdata_i = 8'($urandom);
            check(busy_o == 1'b1, "R3", "busy at beat start", busy_o, 1);
            cnt = 0;
            while (wait_o && cnt < 8) begin
                cnt++;
                check(rdata_o == 8'h00, "R6", "rdata quiet while stalled", rdata_o, 0);
                step();
            end
            check(cnt == int'(wn), "R4", "stall cycles before beat", cnt, wn);
            idx = int'((a[7:0] + 8'(k)));
            if (is_rd) begin
                check(rdata_o == model[idx], "R5/R6", "read byte", rdata_o, model[idx]);
            end else if (rw_i) begin
                model[idx] = wdata_i;   // R7
            end
            step();
        end
        check(busy_o == 1'b0, "R3", "idle after final beat", busy_o, 0);
        check(proto_err_o == (mode != 0), "R8", "error pulse", proto_err_o, mode != 0);
        rd_i = 1'b0; wr_i = 1'b0; bip_i = 1'b0; rw_i = 1'b0;
        addr_i = '0; size_i = '0;
        if (mode != 0) begin
            step();
            check(proto_err_o == 1'b0, "R8", "error lasts one cycle", proto_err_o, 0);
        end
    endtask

    task automatic nop_phase(input bit both);
        addr_i = $urandom; size_i = 2'b11; rd_i = both; wr_i = both;
        step();
        check(busy_o == 1'b0, "R2", "no data phase after no-op", busy_o, 0);
        check(wait_o == 1'b0, "R2", "no stall after no-op", wait_o, 0);
        check(rdata_o == 8'h00, "R6", "rdata idle", rdata_o, 0);
        rd_i = 1'b0; wr_i = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        process::self().srandom(32'd2024);
        @(negedge clk);
        rst = 1'b1;
        step();
        check(busy_o == 0 && wait_o == 0 && proto_err_o == 0 && rdata_o == 0,
              "R1", "outputs in reset", {busy_o, wait_o, proto_err_o, rdata_o}, 0);
        rst = 1'b0;
        check(busy_o == 0 && wait_o == 0 && proto_err_o == 0 && rdata_o == 0,
              "R1", "outputs after reset", {busy_o, wait_o, proto_err_o, rdata_o}, 0);

        // fill the whole memory, R7
        for (int b = 0; b < 32; b++) xfer(32'(b * 8), 2'b11, 1'b0, 2'(b), 0, 0, -1);

        // R2 no-op with both strobes low and both high
        nop_phase(1'b0);
        nop_phase(1'b1);

        // R5 wrap from FF to 00, read with stalls of 2
        xfer(32'hABCD_00FE, 2'b11, 1'b1, 2'd2, 0, 0, -1);
        // R5 wrapping write, then read back
        xfer(32'h0000_01FD, 2'b10, 1'b0, 2'd1, 0, 0, -1);
        xfer(32'h0000_00FD, 2'b10, 1'b1, 2'd0, 0, 0, -1);

        // R7 beat with rw low leaves the byte unchanged
        xfer(32'h0000_0040, 2'b10, 1'b0, 2'd3, 0, 0, 2);
        xfer(32'h0000_0040, 2'b10, 1'b1, 2'd3, 0, 0, -1);

        // R8 early flag drop and late flag, each followed by readback
        xfer(32'h0000_0080, 2'b11, 1'b0, 2'd0, 1, 2, -1);
        xfer(32'h0000_0080, 2'b11, 1'b1, 2'd0, 0, 0, -1);
        xfer(32'h0000_0090, 2'b01, 1'b1, 2'd2, 2, 0, -1);
        xfer(32'h0000_0010, 2'b00, 1'b0, 2'd1, 2, 0, -1);

        // constrained random traffic, back to back
        for (int t = 0; t < 60; t++) begin
            xfer($urandom, 2'($urandom), 1'($urandom), 2'($urandom), 0, 0,
                 ($urandom % 4 == 0) ? int'($urandom % 8) : -1);
            if ($urandom % 5 == 0) nop_phase(1'($urandom));
        end

        // final readback of the whole memory
        for (int b = 0; b < 32; b++) xfer(32'(b * 8), 2'b11, 1'b1, 2'd0, 0, 0, -1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule